// File: doc/BRIEF.md
# Three-Exposure HDR Pixel Merger

This block turns three co-located pixel streams into one linear high-dynamic-range stream. The three streams carry the same scene position taken with a short, a medium and a long exposure. Each stream supplies one code per transaction. Each code goes through a programmable inverse camera response table, which gives a linear value. That value is then scaled by a programmable per-exposure gain, equal to the reciprocal of the exposure time in fixed point, and saturated to the output width. A second programmable table holds a Gaussian-shaped weight for every code. The weights favour well-exposed samples and give zero weight to clipped or unreliable ones.

The output is the weighted mean of the three exposure-normalised values. A pipelined restoring divider that produces one quotient bit per stage computes it, so the block accepts one triplet per clock. If all three weights are zero, the block outputs the medium value in place of the mean. Back-pressure from the output stalls the whole pipeline. The three input streams are joined: a triplet is consumed only when all three are valid at the same time. Tables and gains are loaded through a small write port while no pixels are in flight.

Top module: `hdr_merge3`

## Requirements
- R1: After reset, `out_valid` is low and each of the three gains is 1.0 (256 with 8 fractional bits). A merge done before any gain write therefore uses the response table values unscaled.
- R2: `s_ready`, `m_ready` and `l_ready` always carry the same value. It is high only in a cycle where all three valids are high and `cfg_we` is low. One triplet is consumed in each cycle where it is high.
- R3: The linear value of a code is the entry at that code's address in the response table. If only one exposure has a nonzero weight, the output is that exposure's normalised value.
- R4: The normalised value of exposure i is min((linear * gain_i) >> 8, 2^18-1).
- R5: Each exposure is weighted by the weight-table entry at its own code. All three exposures use the same weight table.
- R6: When the weight sum W is nonzero, `out_pix` = floor(sum(w_i * n_i) / W), where n_i is the normalised value of exposure i.
- R7: When all three weights are zero, `out_pix` equals the medium exposure's normalised value.
- R8: While `out_valid` is high and `out_ready` is low, the next cycle still has `out_valid` high and `out_pix` unchanged.
- R9: With `out_ready` held high and triplets offered every cycle, one result leaves in every cycle, in the order the triplets were accepted. When the output register is empty and a complete triplet is offered with no write, the triplet is accepted.
- R10: A write with `cfg_we` high places `cfg_data` according to `cfg_sel`: 0 writes the response table at `cfg_addr`; 1 writes the weight table at `cfg_addr`; 2 writes gain `cfg_addr` (0 short, 1 medium, 2 long) from the low 16 bits. A gain write to an address of 3 or above, or any write with `cfg_sel` = 3, changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | Short-exposure code valid |
| s_ready | output | 1 | Short-exposure code accepted |
| s_code | input | 8 | Short-exposure pixel code |
| m_valid | input | 1 | Medium-exposure code valid |
| m_ready | output | 1 | Medium-exposure code accepted |
| m_code | input | 8 | Medium-exposure pixel code |
| l_valid | input | 1 | Long-exposure code valid |
| l_ready | output | 1 | Long-exposure code accepted |
| l_code | input | 8 | Long-exposure pixel code |
| out_valid | output | 1 | Merged pixel valid |
| out_ready | input | 1 | Downstream accepts merged pixel |
| out_pix | output | 18 | Merged linear pixel, 10 integer and 8 fractional bits |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Write target: response table, weight table, gain, none |
| cfg_addr | input | 8 | Table address or gain index |
| cfg_data | input | 18 | Write data |

## Verification
A downstream stall and the arrival of a new complete triplet can fall in the same cycle. The stall must then block the join and freeze the whole pipeline without losing or duplicating a pixel. The bench provokes this by drawing each input valid and `out_ready` at random every cycle, with one run where `out_ready` is high only a fifth of the time. It judges the outcome two ways: every result is compared in order against a queue of values computed by a reference function, and the held output is checked to stay unchanged across every stalled cycle.

// File: rtl/hdr_merge3.sv
module hdr_merge3 #(
  parameter int CODE_W    = 8,
  parameter int LIN_W     = 18,
  parameter int WT_W      = 8,
  parameter int GAIN_W    = 16,
  parameter int GAIN_FRAC = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [CODE_W-1:0] s_code,
  input  logic              m_valid,
  output logic              m_ready,
  input  logic [CODE_W-1:0] m_code,
  input  logic              l_valid,
  output logic              l_ready,
  input  logic [CODE_W-1:0] l_code,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [LIN_W-1:0]  out_pix,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [CODE_W-1:0] cfg_addr,
  input  logic [LIN_W-1:0]  cfg_data
);
  localparam int DEPTH = 1 << CODE_W;
  localparam int SC_W  = LIN_W + GAIN_W;
  localparam int DEN_W = WT_W + 2;
  localparam int NUM_W = WT_W + LIN_W + 2;
  localparam int STG   = LIN_W;
  localparam int CW    = (NUM_W > DEN_W + STG) ? NUM_W : DEN_W + STG;
  localparam logic [LIN_W-1:0] LIN_MAX = {LIN_W{1'b1}};

  logic [LIN_W-1:0]  resp [DEPTH];
  logic [WT_W-1:0]   wtab [DEPTH];
  logic [GAIN_W-1:0] gain [3];

  logic en, take;
  logic v1, v2, v3;
  logic [CODE_W-1:0] c1 [3];
  logic [LIN_W-1:0]  lin2 [3];
  logic [WT_W-1:0]   w2 [3];
  logic [WT_W-1:0]   w3 [3];
  logic [LIN_W-1:0]  s3 [3];
  logic [LIN_W-1:0]  sc [3];
  logic [NUM_W-1:0]  num;
  logic [DEN_W-1:0]  den;

  logic              vv [STG+1];
  logic [CW-1:0]     rr [STG+1];
  logic [DEN_W-1:0]  dd [STG+1];
  logic [LIN_W-1:0]  qq [STG+1];
  logic [LIN_W-1:0]  ff [STG+1];
  logic [CW-1:0]     rn [STG];
  logic [LIN_W-1:0]  qn [STG];

  assign out_valid = vv[STG];
  assign en        = !out_valid || out_ready;
  assign take      = en && s_valid && m_valid && l_valid && !cfg_we;
  assign s_ready   = take;
  assign m_ready   = take;
  assign l_ready   = take;
  assign out_pix   = (dd[STG] == '0) ? ff[STG] : qq[STG];

  always_ff @(posedge clk) begin
    if (cfg_we && cfg_sel == 2'd0) resp[cfg_addr] <= cfg_data;
    if (cfg_we && cfg_sel == 2'd1) wtab[cfg_addr] <= cfg_data[WT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) gain[i] <= GAIN_W'(1) << GAIN_FRAC;
    end else if (cfg_we && cfg_sel == 2'd2 && cfg_addr < CODE_W'(3)) begin
      gain[cfg_addr[1:0]] <= cfg_data[GAIN_W-1:0];
    end
  end

  always_comb begin
    logic [SC_W-1:0] prod;
    for (int i = 0; i < 3; i++) begin
      prod  = (SC_W'(lin2[i]) * SC_W'(gain[i])) >> GAIN_FRAC;
      sc[i] = (|prod[SC_W-1:LIN_W]) ? LIN_MAX : prod[LIN_W-1:0];
    end
  end

  always_comb begin
    num = '0;
    den = '0;
    for (int i = 0; i < 3; i++) begin
      num = num + NUM_W'(w3[i]) * NUM_W'(s3[i]);
      den = den + DEN_W'(w3[i]);
    end
  end

  always_comb begin
    logic [CW-1:0] dsh;
    for (int j = 0; j < STG; j++) begin
      dsh   = CW'(dd[j]) << (STG - 1 - j);
      rn[j] = (rr[j] >= dsh) ? rr[j] - dsh : rr[j];
      qn[j] = qq[j] | ((rr[j] >= dsh) ? (LIN_W'(1) << (STG - 1 - j)) : '0);
    end
  end

  always_ff @(posedge clk) begin
    if (en) begin
      c1[0] <= s_code;
      c1[1] <= m_code;
      c1[2] <= l_code;
      for (int i = 0; i < 3; i++) begin
        lin2[i] <= resp[c1[i]];
        w2[i]   <= wtab[c1[i]];
        s3[i]   <= sc[i];
        w3[i]   <= w2[i];
      end
      rr[0] <= CW'(num);
      dd[0] <= den;
      qq[0] <= '0;
      ff[0] <= s3[1];
      for (int j = 0; j < STG; j++) begin
        rr[j+1] <= rn[j];
        dd[j+1] <= dd[j];
        qq[j+1] <= qn[j];
        ff[j+1] <= ff[j];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
      v3 <= 1'b0;
      for (int j = 0; j <= STG; j++) vv[j] <= 1'b0;
    end else if (en) begin
      v1    <= take;
      v2    <= v1;
      v3    <= v2;
      vv[0] <= v3;
      for (int j = 0; j < STG; j++) vv[j+1] <= vv[j];
    end
  end
endmodule

// File: rtl/hdr_merge3_chk.sv
module hdr_merge3_chk #(
  parameter int LIN_W = 18
) (
  input logic             clk,
  input logic             rst_n,
  input logic             s_valid,
  input logic             m_valid,
  input logic             l_valid,
  input logic             s_ready,
  input logic             m_ready,
  input logic             l_ready,
  input logic             cfg_we,
  input logic             out_valid,
  input logic             out_ready,
  input logic [LIN_W-1:0] out_pix
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) !rst_n |=> !out_valid);

  // R2
  ready_same_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_ready == m_ready) && (m_ready == l_ready));

  // R2
  join_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> (s_valid && m_valid && l_valid && !cfg_we));

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pix)));

  // R9
  free_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && s_valid && m_valid && l_valid && !cfg_we) |-> s_ready);
endmodule

bind hdr_merge3 hdr_merge3_chk #(.LIN_W(LIN_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .s_valid(s_valid), .m_valid(m_valid), .l_valid(l_valid),
  .s_ready(s_ready), .m_ready(m_ready), .l_ready(l_ready),
  .cfg_we(cfg_we), .out_valid(out_valid), .out_ready(out_ready),
  .out_pix(out_pix)
);

// File: tb/sim_hdr_merge3.sv
module sim_hdr_merge3;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s_valid = 0, m_valid = 0, l_valid = 0;
  logic s_ready, m_ready, l_ready;
  logic [7:0] s_code = 0, m_code = 0, l_code = 0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [17:0] out_pix;
  logic cfg_we = 0;
  logic [1:0] cfg_sel = 0;
  logic [7:0] cfg_addr = 0;
  logic [17:0] cfg_data = 0;

  always #2 clk = ~clk;

  hdr_merge3 u0 (
    .clk(clk), .rst_n(rst_n),
    .s_valid(s_valid), .s_ready(s_ready), .s_code(s_code),
    .m_valid(m_valid), .m_ready(m_ready), .m_code(m_code),
    .l_valid(l_valid), .l_ready(l_ready), .l_code(l_code),
    .out_valid(out_valid), .out_ready(out_ready), .out_pix(out_pix),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_addr(cfg_addr), .cfg_data(cfg_data)
  );

  int checks = 0;
  int failures = 0;
  longint resp_m [256];
  longint wt_m [256];
  longint gain_m [3];
  longint exp_q [$];
  int first_o, last_o, nout;

  task automatic chk(bit ok, string req, longint act, longint expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic longint norm(int code, int i);
    longint p = (resp_m[code] * gain_m[i]) >> 8;
    return (p > 262143) ? 262143 : p;
  endfunction

  function automatic longint model(int a, int b, int c);
    longint n0 = norm(a, 0), n1 = norm(b, 1), n2 = norm(c, 2);
    longint d = wt_m[a] + wt_m[b] + wt_m[c];
    longint n = wt_m[a] * n0 + wt_m[b] * n1 + wt_m[c] * n2;
    return (d == 0) ? n1 : n / d;
  endfunction

  function automatic int zcode();
    return ($urandom % 2) ? int'($urandom % 6) : 250 + int'($urandom % 6);
  endfunction

  function automatic int mcode();
    return 6 + int'($urandom % 244);
  endfunction

  task automatic pick(int mode, output int pc [3]);
    for (int i = 0; i < 3; i++) begin
      case (mode)
        1: pc[i] = zcode();
        2: pc[i] = 160 + int'($urandom % 96);
        3: pc[i] = (i == 0) ? mcode() : zcode();
        4: pc[i] = (i == 2) ? zcode() : mcode();
        default: pc[i] = int'($urandom % 256);
      endcase
    end
    if (mode == 3 && ($urandom % 2)) begin
      pc[0] = zcode();
      pc[2] = mcode();
    end
  endtask

  task automatic cfg_write(int sel, int addr, longint data);
    @(negedge clk);
    cfg_we = 1; cfg_sel = 2'(sel); cfg_addr = 8'(addr); cfg_data = 18'(data);
    if (sel == 0) resp_m[addr] = data;
    if (sel == 1) wt_m[addr] = data & 255;
    if (sel == 2 && addr < 3) gain_m[addr] = data & 65535;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic run(int n, int pv, int pr, int mode, string tag);
    int sent = 0;
    int cyc = 0;
    bit hv = 0;
    logic [17:0] hp = 0;
    int pc [3];
    bit vv [3] = '{0, 0, 0};
    first_o = -1; last_o = -1; nout = 0;
    pick(mode, pc);
    while (sent < n || exp_q.size() > 0) begin
      @(negedge clk);
      cyc++;
      if (hv) chk(out_valid && out_pix == hp, "R8", out_pix, hp);
      for (int i = 0; i < 3; i++)
        if (!vv[i] && sent < n && int'($urandom % 100) < pv) vv[i] = 1;
      s_valid = vv[0]; m_valid = vv[1]; l_valid = vv[2];
      s_code = 8'(pc[0]); m_code = 8'(pc[1]); l_code = 8'(pc[2]);
      out_ready = int'($urandom % 100) < pr;
      #1;
      chk(s_ready == m_ready && m_ready == l_ready, "R2", s_ready, m_ready);
      if (s_ready) begin
        chk(vv[0] && vv[1] && vv[2], "R2", 1, vv[0] && vv[1] && vv[2]);
        exp_q.push_back(model(pc[0], pc[1], pc[2]));
        sent++;
        for (int i = 0; i < 3; i++) vv[i] = 0;
        pick(mode, pc);
      end
      hv = out_valid && !out_ready;
      hp = out_pix;
      if (out_valid && out_ready) begin
        longint e;
        if (exp_q.size() == 0) begin
          chk(0, tag, out_pix, -1);
        end else begin
          e = exp_q.pop_front();
          chk(out_pix == 18'(e), tag, out_pix, e);
        end
        if (first_o < 0) first_o = cyc;
        last_o = cyc;
        nout++;
      end
    end
    @(negedge clk);
    s_valid = 0; m_valid = 0; l_valid = 0; out_ready = 1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL R9 watchdog expired actual=0 expected=1");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 3; i++) gain_m[i] = 256;
    repeat (3) @(negedge clk);
    chk(out_valid == 0, "R1", out_valid, 0);
    rst_n = 1;
    @(negedge clk);
    chk(out_valid == 0, "R1", out_valid, 0);
    chk(s_ready == 0, "R2", s_ready, 0);

    for (int c = 0; c < 256; c++) begin
      int dv;
      cfg_write(0, c, longint'(c) * c * 3 + longint'(c) * 64);
      dv = 255 - ((c - 128) * (c - 128)) / 64;
      cfg_write(1, c, (c < 6 || c > 249) ? 0 : dv);
    end

    @(negedge clk);
    s_valid = 1; m_valid = 1; l_valid = 1;
    cfg_we = 1; cfg_sel = 2'd3; cfg_addr = 0; cfg_data = 18'h3FFFF;
    #1;
    chk(s_ready == 0 && m_ready == 0 && l_ready == 0, "R2", s_ready, 0);
    @(negedge clk);
    cfg_we = 0; s_valid = 0; m_valid = 0; l_valid = 0;

    run(30, 90, 90, 0, "R1");
    cfg_write(2, 0, 16'h0400);
    cfg_write(2, 1, 16'h0100);
    cfg_write(2, 2, 16'h0040);
    run(200, 70, 60, 0, "R6");
    run(40, 80, 70, 1, "R7");
    run(40, 80, 70, 3, "R3");
    run(40, 80, 70, 4, "R5");
    run(40, 100, 100, 0, "R9");
    chk(nout == 40 && last_o - first_o == 39, "R9", last_o - first_o, 39);
    cfg_write(2, 3, 0);
    cfg_write(3, 0, 0);
    run(40, 80, 80, 0, "R10");
    cfg_write(2, 0, 16'hFFFF);
    cfg_write(2, 2, 16'h8000);
    run(60, 80, 50, 2, "R4");
    run(60, 90, 20, 0, "R8");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule